// File: doc/BRIEF.md
# Kernel-Width Multi-Pixel Fetch Buffer

This block is a frame store for 8-bit grayscale pixels that feeds a convolution datapath. On the write side it takes one pixel per clock. The pixel goes either to the location held by an internal write pointer, which then advances by one, or to an address given on the port, after which the pointer continues from the next location. On the read side the user gives a start address and a kernel width K. One clock later the block returns K neighbouring pixels packed into a single wide word, so a whole kernel row arrives in one transfer.

K is chosen at run time for each request. It may be any value from 1 to 7, not only a power of two. The store is split into eight banks selected by the low three address bits. Any run of up to seven consecutive pixels therefore touches each bank at most once, and the whole run is read in one cycle. The frame size is set by the parameters `IMG_W` and `IMG_H`, and a 512 by 512 frame is a legal setting. The defaults are kept small.

Top module: `kwfetch_buf`

## Requirements
- R1: While reset is asserted and until the first read request completes, `rd_valid` is 0 and `rd_data` is all zero. The first pointer-addressed write after reset lands at address 0.
- R2: A write with `wr_en`=1 and `wr_sel`=0 stores `wr_data` at the write pointer, and the pointer then advances by one. After address DEPTH-1 the pointer goes to address 0.
- R3: A write with `wr_en`=1 and `wr_sel`=1 stores `wr_data` at `wr_addr`. The pointer becomes `wr_addr`+1, wrapping to 0 after DEPTH-1.
- R4: `rd_valid` is 1 in exactly the cycle after each cycle in which `rd_req` is 1, and 0 otherwise. Back-to-back requests give back-to-back valid cycles.
- R5: For a request with start address A and width K (1 to 7), byte j of `rd_data` (bits 8j+7 down to 8j) holds the pixel stored at address A+j, for every j below K. The pixel at the lowest address is in byte 0.
- R6: Bytes j >= K of `rd_data` are zero. A request with K=0 returns an all-zero word with `rd_valid`=1.
- R7: A read whose span passes address DEPTH-1 continues at address 0. Byte j then holds the pixel at (A+j) modulo DEPTH.
- R8: While `rd_req` is 0, `rd_data` keeps the value of the last completed read, even while writes take place.
- R9: A read and a write may occur in the same cycle. If the write hits a location inside the read span, the read returns the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_sel | input | 1 | 1: write at `wr_addr`; 0: write at the internal pointer |
| wr_addr | input | AW | Explicit write address (below DEPTH) |
| wr_data | input | 8 | Pixel to store |
| rd_req | input | 1 | Start a group read this cycle |
| rd_addr | input | AW | Address of the first pixel of the group (below DEPTH) |
| rd_k | input | 3 | Number of pixels to fetch, 0 to 7 |
| rd_valid | output | 1 | Group word valid (one cycle after `rd_req`) |
| rd_data | output | 56 | Packed group, lowest address in the low byte |

## Verification
The bound checker checks on every cycle the rules that need no knowledge of stored contents:
- the valid strobe follows each request by exactly one cycle;
- bytes at or above the requested width read as zero;
- the output word holds still between requests;
- the write pointer steps by one or reloads from the given address, with the wrap at the top of the frame.

Whether each byte carries the correct pixel can only be shown by the bench's scenarios. These include an exhaustive sweep of every start address against every width on a small frame, reads that wrap past the last address, and overwrites through both write modes. The bench also covers a read that collides with a write in the same cycle.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned NBANK  = 8;
  localparam int unsigned BANK_W = 3;
  localparam int unsigned KMAX   = 7;
  localparam int unsigned K_W    = 3;
  localparam int unsigned DW     = PIX_W * KMAX;

  typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/fb_wr_ptr.sv
module fb_wr_ptr #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_addr,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    waddr = wr_sel ? wr_addr : ptr_q;
    ptr_d = ptr_q;
    if (wr_en) begin
      if (waddr == LAST) ptr_d = '0;
      else               ptr_d = waddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/fb_bank.sv
module fb_bank
  import fb_pkg::*;
#(
  parameter int unsigned ROWS = 128,
  parameter int unsigned RW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  pix_t          wdata,
  input  logic          re,
  input  logic [RW-1:0] raddr,
  output pix_t          q
);
  pix_t mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register samples the array before a same-edge write lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/fb_rd_map.sv
module fb_rd_map
  import fb_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10,
  parameter int unsigned RW    = 7
) (
  input  logic                     req,
  input  logic [AW-1:0]            start,
  input  logic [K_W-1:0]           k,
  output logic [NBANK-1:0]         re,
  output logic [NBANK-1:0][RW-1:0] row
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] lane;
    logic [PW-1:0]     pix_raw;
    logic [PW-1:0]     pix;

    always_comb begin
      // position of bank b inside the requested run
      lane    = BANK_W'(b) - start[BANK_W-1:0];
      pix_raw = {1'b0, start} + PW'(lane);
      pix     = (pix_raw >= DEPTH_P) ? (pix_raw - DEPTH_P) : pix_raw;
      row[b]  = pix[AW-1:BANK_W];
      re[b]   = req && (lane < k);
    end
  end
endmodule

// File: rtl/fb_rd_align.sv
module fb_rd_align
  import fb_pkg::*;
(
  input  logic [NBANK-1:0][PIX_W-1:0] bank_q,
  input  logic [BANK_W-1:0]           lane0,
  input  logic [K_W-1:0]              k,
  output logic [DW-1:0]               data
);
  for (genvar j = 0; j < KMAX; j++) begin : g_lane
    logic [BANK_W-1:0] src;
    always_comb begin
      src = lane0 + BANK_W'(j);
      data[j*PIX_W +: PIX_W] = (K_W'(j) < k) ? bank_q[src] : '0;
    end
  end
endmodule

// File: rtl/kwfetch_buf.sv
module kwfetch_buf
  import fb_pkg::*;
#(
  parameter int unsigned IMG_W = 32,
  parameter int unsigned IMG_H = 32,
  parameter int unsigned DEPTH = IMG_W * IMG_H,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [AW-1:0]     wr_addr,
  input  logic [PIX_W-1:0]  wr_data,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic [K_W-1:0]    rd_k,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  localparam int unsigned ROWS = DEPTH / NBANK;
  localparam int unsigned RW   = AW - BANK_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // write address
  logic [AW-1:0] waddr;
  logic [AW-1:0] wr_ptr;

  fb_wr_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_addr(wr_addr),
    .waddr  (waddr),
    .ptr    (wr_ptr)
  );

  // read address spread over the banks
  logic [NBANK-1:0]         bank_re;
  logic [NBANK-1:0][RW-1:0] bank_row;

  fb_rd_map #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) u_map (
    .req  (rd_req),
    .start(rd_addr),
    .k    (rd_k),
    .re   (bank_re),
    .row  (bank_row)
  );

  // banks
  logic [NBANK-1:0][PIX_W-1:0] bank_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (waddr[BANK_W-1:0] == BANK_W'(b));

    fb_bank #(.ROWS(ROWS), .RW(RW)) u_bank (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .we   (bank_we),
      .waddr(waddr[AW-1:BANK_W]),
      .wdata(wr_data),
      .re   (bank_re[b]),
      .raddr(bank_row[b]),
      .q    (bank_q[b])
    );
  end

  // request context kept for the cycle the data appears
  logic              valid_q, valid_d;
  logic [BANK_W-1:0] lane0_q, lane0_d;
  logic [K_W-1:0]    k_q, k_d;

  always_comb begin
    valid_d = rd_req;
    lane0_d = rd_req ? rd_addr[BANK_W-1:0] : lane0_q;
    k_d     = rd_req ? rd_k : k_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      lane0_q <= '0;
      k_q     <= '0;
    end else begin
      valid_q <= valid_d;
      lane0_q <= lane0_d;
      k_q     <= k_d;
    end
  end

  fb_rd_align u_align (
    .bank_q(bank_q),
    .lane0 (lane0_q),
    .k     (k_q),
    .data  (rd_data)
  );

  assign rd_valid = valid_q;
endmodule

// File: rtl/fb_checker.sv
module fb_checker
  import fb_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           wr_sel,
  input logic [AW-1:0]  wr_addr,
  input logic [AW-1:0]  wr_ptr,
  input logic           rd_req,
  input logic [K_W-1:0] rd_k,
  input logic           rd_valid,
  input logic [DW-1:0]  rd_data
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  logic [K_W-1:0] k_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      k_seen <= '0;
    else if (rd_req) k_seen <= rd_k;
  end

  assert_valid_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_valid_without_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_upper_bytes_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data >> (8 * k_seen)) == '0));

  assert_data_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_data));

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (wr_ptr == step($past(wr_ptr))));

  assert_ptr_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (wr_ptr == step($past(wr_addr))));

  assert_ptr_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr));
endmodule

bind kwfetch_buf fb_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_addr (wr_addr),
  .wr_ptr  (wr_ptr),
  .rd_req  (rd_req),
  .rd_k    (rd_k),
  .rd_valid(rd_valid),
  .rd_data (rd_data)
);

// File: tb/sim_kwfetch_buf.sv
`timescale 1ns/1ps
module sim_kwfetch_buf;
  localparam int DEPTH = 128;
  localparam int AW    = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, wr_sel;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [2:0]    rd_k;
  logic          rd_valid;
  logic [55:0]   rd_data;

  always #10 clk = ~clk;

  kwfetch_buf #(.IMG_W(16), .IMG_H(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_k(rd_k),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] model [DEPTH];
  int mptr = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] expect_word(input int a, input int k);
    logic [55:0] w = '0;
    for (int j = 0; j < 7; j++)
      if (j < k) w[j*8 +: 8] = model[(a + j) % DEPTH];
    return w;
  endfunction

  task automatic wr_px(input bit sel, input int addr, input logic [7:0] v);
    int dst;
    @(negedge clk);
    rd_req  = 1'b0;
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_addr = AW'(addr);
    wr_data = v;
    dst = sel ? addr : mptr;
    model[dst] = v;
    mptr = (dst + 1) % DEPTH;
  endtask

  task automatic do_read(input int a, input int k);
    logic [55:0] exp, held;
    string tag;
    @(negedge clk);
    wr_en   = 1'b0;
    rd_req  = 1'b1;
    rd_addr = AW'(a);
    rd_k    = 3'(k);
    exp = expect_word(a, k);
    @(negedge clk);
    rd_req = 1'b0;
    tag = (a + k > DEPTH) ? "R7 wrapped span" : "R5 pixel order";
    check(rd_valid == 1'b1, "R4 valid after request", 64'(rd_valid), 64'd1);
    check(rd_data == exp, tag, 64'(rd_data), 64'(exp));
    check((rd_data >> (8 * k)) == '0, "R6 unused bytes zero",
          64'(rd_data >> (8 * k)), 64'd0);
    held = rd_data;
    @(negedge clk);
    check(rd_valid == 1'b0, "R4 single-cycle valid", 64'(rd_valid), 64'd0);
    check(rd_data == held, "R8 data held", 64'(rd_data), 64'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [55:0] exp;
    logic [55:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
    rd_req = 1'b0; rd_addr = '0; rd_k = '0;
    repeat (3) @(negedge clk);
    check(rd_valid == 1'b0, "R1 valid in reset", 64'(rd_valid), 64'd0);
    check(rd_data == '0, "R1 data in reset", 64'(rd_data), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_valid == 1'b0, "R1 valid after reset", 64'(rd_valid), 64'd0);
    check(rd_data == '0, "R1 data after reset", 64'(rd_data), 64'd0);

    // R1/R2: pointer-addressed fill of the whole frame starting at 0
    for (int a = 0; a < DEPTH; a++) wr_px(1'b0, 0, 8'((a * 29 + 7) & 255));
    // R2: pointer wrapped, next pointer write lands on address 0
    wr_px(1'b0, 0, 8'hA5);
    do_read(0, 2);
    // R3: explicit write then pointer continues after it
    wr_px(1'b1, 77, 8'h3C);
    wr_px(1'b0, 0, 8'hC3);
    do_read(76, 4);
    // R3: explicit write at the top, pointer wraps to 0
    wr_px(1'b1, DEPTH - 1, 8'h5A);
    wr_px(1'b0, 0, 8'h66);
    do_read(DEPTH - 2, 5);

    // R5/R6/R7: every start address against every width
    for (int a = 0; a < DEPTH; a++)
      for (int k = 0; k < 8; k++)
        do_read(a, k);

    // R4: back-to-back requests
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd_req  = 1'b1;
      rd_addr = AW'(i * 19 + 3);
      rd_k    = 3'(7 - i);
      exp = expect_word(i * 19 + 3, 7 - i);
      @(negedge clk);
      check(rd_valid == 1'b1, "R4 back-to-back valid", 64'(rd_valid), 64'd1);
      check(rd_data == exp, "R4 back-to-back data", 64'(rd_data), 64'(exp));
    end
    rd_req = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R4 valid drops", 64'(rd_valid), 64'd0);

    // R8: writes while idle leave the output alone
    held = rd_data;
    wr_px(1'b1, 60, 8'h11);
    wr_px(1'b0, 0, 8'h22);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check(rd_data == held, "R8 held across writes", 64'(rd_data), 64'(held));

    // R9: same-cycle write inside the read span returns the older pixel
    @(negedge clk);
    exp     = expect_word(40, 3);
    wr_en   = 1'b1; wr_sel = 1'b1; wr_addr = AW'(41); wr_data = 8'hEE;
    rd_req  = 1'b1; rd_addr = AW'(40); rd_k = 3'd3;
    model[41] = 8'hEE;
    mptr = 42;
    @(negedge clk);
    wr_en = 1'b0; rd_req = 1'b0;
    check(rd_valid == 1'b1, "R9 valid with write", 64'(rd_valid), 64'd1);
    check(rd_data == exp, "R9 old value on collision", 64'(rd_data), 64'(exp));
    do_read(40, 3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule